// File: doc/BRIEF.md
# Floating-Point Status Register Unit

This block keeps the user-visible floating-point exception flags and the dynamic rounding mode of a processor core. Software reaches both through a CSR port addressed by a 12-bit register number. The port has a strobed write side and a combinational read side. The floating-point datapath reports exception conditions for each completed operation. The block ORs these reports into sticky flags. Once a flag is set, it stays set until software writes it back to zero. Setting a flag raises no trap or interrupt, so software must read the flags to see them.

The block also resolves the 3-bit rounding field of each instruction. A static field is used as it is. The dynamic code selects the stored mode instead. The block drives out the effective rounding mode and an illegal-encoding indication. The field is checked for legality on every instruction, whether or not the result depends on rounding.

Top module: `fp_status_csr`

## Requirements
- R1: After a synchronous active-high reset, all five flags read 0 and the stored rounding mode reads 000 (nearest, ties to even).
- R2: The read port returns the flags at address 0x001 in bits 4:0 and the rounding mode at 0x002 in bits 2:0. All other bits read 0, and the error output is 0 for these addresses.
- R3: When exc_valid is 1, each set bit of exc_flags sets the matching flag on the next clock edge. The flag bits are invalid=4, divide-by-zero=3, overflow=2, underflow=1, inexact=0. Hardware never clears a flag.
- R4: A write to 0x001 or 0x003 replaces the flags with the written bits 4:0. Any exception reported in the same cycle is ORed into the new value.
- R5: A write to 0x002 stores bits 2:0 as the rounding mode and leaves the flags alone, apart from any exception reported in the same cycle.
- R6: Address 0x003 reads and writes both fields together: rounding mode in bits 7:5 and flags in bits 4:0, with bits 31:8 zero. It uses the same storage as 0x001 and 0x002.
- R7: A write to any other address changes nothing. A read of any other address returns 0 and sets rd_err to 1.
- R8: A static rm of 000 to 100 is passed to eff_rm unchanged, with rm_illegal at 0.
- R9: A static rm of 101 or 110 sets rm_illegal to 1.
- R10: An rm of 111 makes eff_rm equal the stored mode. rm_illegal is 1 when the stored mode is 101, 110 or 111.
- R11: With exc_valid at 0 and no write to a flag address, the flags hold their value. This applies even when exc_flags carries set bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csr_wr_en | input | 1 | Write strobe |
| csr_wr_addr | input | 12 | Write register number |
| csr_wr_data | input | 32 | Write data |
| csr_rd_addr | input | 12 | Read register number |
| csr_rd_data | output | 32 | Read data, combinational |
| csr_rd_err | output | 1 | Read of an unmapped number |
| exc_valid | input | 1 | Datapath exception report valid |
| exc_flags | input | 5 | Reported exception conditions |
| inst_rm | input | 3 | Instruction rounding field |
| eff_rm | output | 3 | Effective rounding mode |
| rm_illegal | output | 1 | Reserved rounding encoding |

## Verification
Any corruption in the flag bits shows up on the read port one cycle after it happens. The same holds for a lost OR or a wrongly decoded write address. The bench reads all three views after every stimulus cycle, so such faults appear at the next check. A wrong stored mode shows up twice: in the read data, and at once on eff_rm and rm_illegal when the instruction field is 111. The bench therefore drives all eight field values after each update.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int CSR_AW  = 12;
  localparam int CSR_DW  = 32;
  localparam int N_FLAGS = 5;
  localparam int RM_W    = 3;
  localparam int ALL_RM_LSB = N_FLAGS;

  localparam logic [CSR_AW-1:0] A_FLAGS = 12'h001;
  localparam logic [CSR_AW-1:0] A_MODE  = 12'h002;
  localparam logic [CSR_AW-1:0] A_BOTH  = 12'h003;

  typedef enum logic [RM_W-1:0] {
    RM_NEAR_EVEN = 3'b000,
    RM_TO_ZERO   = 3'b001,
    RM_DOWNWARD  = 3'b010,
    RM_UPWARD    = 3'b011,
    RM_NEAR_MAX  = 3'b100,
    RM_RSV_A     = 3'b101,
    RM_RSV_B     = 3'b110,
    RM_DYNAMIC   = 3'b111
  } rmode_e;
endpackage

// File: rtl/fpcsr_flags.sv
module fpcsr_flags #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_we,
  input  logic [NF-1:0] sw_val,
  input  logic          hw_valid,
  input  logic [NF-1:0] hw_set,
  output logic [NF-1:0] flags_q
);
  logic [NF-1:0] hw_bits;
  assign hw_bits = hw_set & {NF{hw_valid}};

  for (genvar i = 0; i < NF; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)             bit_q <= 1'b0;
      else if (sw_we)      bit_q <= sw_val[i] | hw_bits[i];
      else if (hw_bits[i]) bit_q <= 1'b1;
    end
    assign flags_q[i] = bit_q;
  end

  // R3: reported conditions are present after the edge, even alongside a write
  p_hw_sets_r3: assert property (@(posedge clk) disable iff (rst)
    hw_valid |=> ((flags_q & $past(hw_set)) == $past(hw_set)));
  // R3: without a software write no flag ever falls
  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    !sw_we |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  // R11: idle inputs leave the flags untouched
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!sw_we && !hw_valid) |=> $stable(flags_q));
endmodule

// File: rtl/fpcsr_mode_reg.sv
module fpcsr_mode_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wval,
  output logic [W-1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (rst)     mode_q <= '0;
    else if (we) mode_q <= wval;
  end

  // R5: the mode changes only on a write
  p_mode_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(mode_q));
  // R5: a write lands as written
  p_mode_load_r5: assert property (@(posedge clk) disable iff (rst)
    we |=> (mode_q == $past(wval)));
endmodule

// File: rtl/fpcsr_rm_resolve.sv
module fpcsr_rm_resolve
  import fpcsr_pkg::*;
(
  input  logic [RM_W-1:0] inst_rm,
  input  logic [RM_W-1:0] dyn_rm,
  output logic [RM_W-1:0] eff_rm,
  output logic            illegal
);
  logic is_dyn;
  assign is_dyn = (inst_rm == RM_DYNAMIC);

  always_comb begin
    eff_rm  = is_dyn ? dyn_rm : inst_rm;
    illegal = 1'b0;
    if (is_dyn) begin
      if (dyn_rm == RM_RSV_A || dyn_rm == RM_RSV_B || dyn_rm == RM_DYNAMIC) illegal = 1'b1;
    end else begin
      if (inst_rm == RM_RSV_A || inst_rm == RM_RSV_B) illegal = 1'b1;
    end
  end
endmodule

// File: rtl/fp_status_csr.sv
module fp_status_csr
  import fpcsr_pkg::*;
#(
  parameter int ADDR_W = CSR_AW,
  parameter int DATA_W = CSR_DW,
  parameter int NF     = N_FLAGS,
  parameter int RW     = RM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_wr_en,
  input  logic [ADDR_W-1:0] csr_wr_addr,
  input  logic [DATA_W-1:0] csr_wr_data,
  input  logic [ADDR_W-1:0] csr_rd_addr,
  output logic [DATA_W-1:0] csr_rd_data,
  output logic              csr_rd_err,
  input  logic              exc_valid,
  input  logic [NF-1:0]     exc_flags,
  input  logic [RW-1:0]     inst_rm,
  output logic [RW-1:0]     eff_rm,
  output logic              rm_illegal
);
  localparam int BOTH_W = NF + RW;

  logic          hit_flags, hit_mode, hit_both;
  logic          we_flags, we_mode;
  logic [RW-1:0] mode_wval;
  logic [NF-1:0] flags_q;
  logic [RW-1:0] mode_q;

  assign hit_flags = (csr_wr_addr == ADDR_W'(A_FLAGS));
  assign hit_mode  = (csr_wr_addr == ADDR_W'(A_MODE));
  assign hit_both  = (csr_wr_addr == ADDR_W'(A_BOTH));
  assign we_flags  = csr_wr_en & (hit_flags | hit_both);
  assign we_mode   = csr_wr_en & (hit_mode  | hit_both);
  assign mode_wval = hit_both ? csr_wr_data[NF +: RW] : csr_wr_data[RW-1:0];

  logic unused_wdata;
  assign unused_wdata = ^csr_wr_data[DATA_W-1:BOTH_W];

  fpcsr_flags #(.NF(NF)) u_flags (
    .clk(clk), .rst(rst), .sw_we(we_flags), .sw_val(csr_wr_data[NF-1:0]),
    .hw_valid(exc_valid), .hw_set(exc_flags), .flags_q(flags_q));

  fpcsr_mode_reg #(.W(RW)) u_mode (
    .clk(clk), .rst(rst), .we(we_mode), .wval(mode_wval), .mode_q(mode_q));

  fpcsr_rm_resolve u_resolve (
    .inst_rm(inst_rm), .dyn_rm(mode_q), .eff_rm(eff_rm), .illegal(rm_illegal));

  always_comb begin
    csr_rd_data = '0;
    csr_rd_err  = 1'b0;
    unique case (csr_rd_addr)
      ADDR_W'(A_FLAGS): csr_rd_data[NF-1:0] = flags_q;
      ADDR_W'(A_MODE):  csr_rd_data[RW-1:0] = mode_q;
      ADDR_W'(A_BOTH):  csr_rd_data[BOTH_W-1:0] = {mode_q, flags_q};
      default:          csr_rd_err = 1'b1;
    endcase
  end

  // R1: state just out of reset
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (flags_q == '0 && mode_q == '0));
  // R7: unmapped reads return zero
  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (rst)
    csr_rd_err |-> (csr_rd_data == '0));
  // R10: dynamic field follows stored mode
  p_dyn_follow_r10: assert property (@(posedge clk) disable iff (rst)
    (inst_rm == RW'(RM_DYNAMIC)) |-> (eff_rm == mode_q));
  // R8: legal static fields pass through
  p_static_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (inst_rm <= RW'(RM_NEAR_MAX)) |-> (eff_rm == inst_rm && !rm_illegal));
  // R7: unmapped write leaves the mode alone
  p_unmapped_wr_r7: assert property (@(posedge clk) disable iff (rst)
    (csr_wr_en && !hit_flags && !hit_mode && !hit_both) |=> $stable(mode_q));
endmodule

// File: tb/fp_status_csr_tb_top.sv
`timescale 1ns/1ps
module fp_status_csr_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_wr_en = 1'b0;
  logic [11:0] csr_wr_addr = '0;
  logic [31:0] csr_wr_data = '0;
  logic [11:0] csr_rd_addr = '0;
  logic [31:0] csr_rd_data;
  logic        csr_rd_err;
  logic        exc_valid = 1'b0;
  logic [4:0]  exc_flags = '0;
  logic [2:0]  inst_rm = '0;
  logic [2:0]  eff_rm;
  logic        rm_illegal;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [4:0] m_flags;
  logic [2:0] m_rm;

  always #4 clk = ~clk;

  fp_status_csr dut_i (
    .clk(clk), .rst(rst), .csr_wr_en(csr_wr_en), .csr_wr_addr(csr_wr_addr),
    .csr_wr_data(csr_wr_data), .csr_rd_addr(csr_rd_addr), .csr_rd_data(csr_rd_data),
    .csr_rd_err(csr_rd_err), .exc_valid(exc_valid), .exc_flags(exc_flags),
    .inst_rm(inst_rm), .eff_rm(eff_rm), .rm_illegal(rm_illegal));

  function automatic logic [2:0] exp_eff(input logic [2:0] f, input logic [2:0] st);
    return (f == 3'b111) ? st : f;
  endfunction
  function automatic logic exp_ill(input logic [2:0] f, input logic [2:0] st);
    return (f == 3'b111) ? (st >= 3'b101) : (f == 3'b101 || f == 3'b110);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    csr_rd_addr = 12'h001; #1;
    chk("R2/R3/R4 flags view", csr_rd_data, {27'b0, m_flags});
    chk("R2 err at flags", {31'b0, csr_rd_err}, 32'd0);
    csr_rd_addr = 12'h002; #1;
    chk("R2/R5 mode view", csr_rd_data, {29'b0, m_rm});
    csr_rd_addr = 12'h003; #1;
    chk("R6 combined view", csr_rd_data, {24'b0, m_rm, m_flags});
    for (int f = 0; f < 8; f++) begin
      inst_rm = 3'(f); #1;
      chk("R8/R9/R10 eff_rm", {29'b0, eff_rm}, {29'b0, exp_eff(3'(f), m_rm)});
      chk("R8/R9/R10 illegal", {31'b0, rm_illegal}, {31'b0, exp_ill(3'(f), m_rm)});
    end
  endtask

  // one clock of stimulus, model updated alongside
  task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d,
                      input logic hv, input logic [4:0] hf);
    logic [4:0] hw;
    @(negedge clk);
    csr_wr_en = we; csr_wr_addr = a; csr_wr_data = d; exc_valid = hv; exc_flags = hf;
    hw = hv ? hf : 5'b0;
    if (we && a == 12'h001)      m_flags = d[4:0] | hw;
    else if (we && a == 12'h003) begin m_flags = d[4:0] | hw; m_rm = d[7:5]; end
    else begin
      m_flags = m_flags | hw;
      if (we && a == 12'h002) m_rm = d[2:0];
    end
    @(posedge clk); #1;
    csr_wr_en = 1'b0; exc_valid = 1'b0; exc_flags = 5'b0;
    check_all();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_flags = '0; m_rm = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    check_all();
    // R7 unmapped read
    csr_rd_addr = 12'h7ff; #1;
    chk("R7 unmapped data", csr_rd_data, 32'd0);
    chk("R7 unmapped err", {31'b0, csr_rd_err}, 32'd1);
    // R3 hardware set, sticky across later reports
    step(0, 12'h0, 0, 1, 5'b10000);
    step(0, 12'h0, 0, 1, 5'b00001);
    // R11 flags on bus without valid ignored
    step(0, 12'h0, 0, 0, 5'b01110);
    // R4 software clear, then write with simultaneous report
    step(1, 12'h001, 32'hffff_ffe0, 0, 5'b0);
    step(1, 12'h001, 32'h0000_0002, 1, 5'b01000);
    // R5 mode write keeps flags, reserved stored modes R10
    step(1, 12'h002, 32'h0000_0005, 0, 5'b0);
    step(1, 12'h002, 32'h0000_0006, 1, 5'b00100);
    step(1, 12'h002, 32'h0000_0007, 0, 5'b0);
    // R6 combined write
    step(1, 12'h003, 32'hffff_ff6b, 0, 5'b0);
    // R7 unmapped writes ignored
    step(1, 12'h000, 32'hffff_ffff, 0, 5'b0);
    step(1, 12'h004, 32'hffff_ffff, 0, 5'b0);
    step(1, 12'h801, 32'h0000_0000, 0, 5'b0);
    step(1, 12'h002, 32'h0000_0004, 0, 5'b0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      int sel;
      sel = $urandom_range(0, 4);
      a = (sel == 0) ? 12'h001 : (sel == 1) ? 12'h002 : (sel == 2) ? 12'h003 :
          (sel == 3) ? 12'($urandom_range(4, 4095)) : 12'h000;
      step(1'($urandom_range(0, 1)), a, $urandom, 1'($urandom_range(0, 1)), 5'($urandom));
    end
    // R1 reset again from a busy state
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1; @(negedge clk); rst = 1'b0;
    m_flags = '0; m_rm = '0;
    check_all();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule